// File: doc/BRIEF.md
# Packet Buffer Host Memory Window

This block lets a host processor reach an on-chip packet buffer through a 4-kbyte page of its own memory space. The host presents an address, a read or write strobe, a byte/word size flag and write data. In the same cycle the block decodes the access. It routes receive status and receive length reads to their input values, receive frame reads to a buffer read port and transmit frame writes to a buffer write port, and acknowledges with `host_ready`. No wait states are added.

Decoding is active only while the memory-mode enable input is high; that input reflects a control bit held elsewhere, which is low after reset. The block enforces the alignment and ordering rules of the window: word accesses must be even, a lone even byte must be completed by its odd partner before a word access, and receive data past a leading random-access window must be read strictly in sequence. An access that breaks a rule is still acknowledged, but it returns zero, has no effect on the buffer and raises a sticky error flag.

Top module: `pbuf_host_window`

## Requirements
- R1: An access is acknowledged (`host_ready` high in the same cycle as the strobe) only when `host_addr[HOST_AW-1:12]` equals `win_page` and `host_addr[11:0]` is 0x400 or above. Any other address gives no acknowledge and no buffer strobe.
- R2: While `mem_en` is low, no access is acknowledged or forwarded, whatever the address.
- R3: Offset 0x400 reads `rx_status` and offset 0x402 reads `rx_length`. A byte read returns the low byte at the even address and the high byte at the odd address, placed in `host_rdata[7:0]` with the upper byte zero.
- R4: A read at offset 0x404+n pulses `buf_rd_en` with `buf_rd_addr` = n. A word read returns `buf_rd_data`, and a byte read returns `{8'h00, buf_rd_data[7:0]}`.
- R5: A write at offset 0xA00+n pulses `buf_wr_en` with `buf_wr_addr` = n, `buf_wr_word` = `host_word` and `buf_wr_data` = `host_wdata` (for a byte, the data is in bits 7:0).
- R6: Receive frame offsets below `RAND_WIN` (118) may be read in any order.
- R7: A receive frame read at offset n ≥ `RAND_WIN` is accepted only if n equals the sequence pointer. The pointer is the offset plus the size (1 or 2) of the last accepted frame read. It is 0 after reset and after an `rx_frame_new` pulse.
- R8: A word access to an odd address is rejected.
- R9: After an accepted byte access to an even address A, word accesses are rejected until a byte access to A+1 is accepted. A byte access to an odd address may be followed directly by a word access.
- R10: Writes to offsets 0x400–0x9FF and reads from offsets 0xA00–0xFFF are rejected.
- R11: A rejected access is still acknowledged. It returns `host_rdata` = 0, strobes neither buffer port, and sets `host_err`, which then stays high until reset.
- R12: After reset, `host_err` is low and, with no strobe, `host_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mem_en | input | 1 | Memory-mode enable |
| win_page | input | HOST_AW-12 | Upper address bits of the window page |
| host_addr | input | HOST_AW | Host byte address |
| host_rd | input | 1 | Read strobe |
| host_wr | input | 1 | Write strobe |
| host_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data |
| host_ready | output | 1 | Same-cycle acknowledge |
| host_err | output | 1 | Sticky rule-violation flag |
| rx_status | input | 16 | Receive status value |
| rx_length | input | 16 | Receive length value |
| rx_frame_new | input | 1 | New receive frame presented; restarts the sequence pointer |
| buf_rd_en | output | 1 | Receive buffer read strobe |
| buf_rd_addr | output | 11 | Receive frame byte offset |
| buf_rd_word | output | 1 | Read size |
| buf_rd_data | input | 16 | Receive buffer data, byte in bits 7:0 |
| buf_wr_en | output | 1 | Transmit buffer write strobe |
| buf_wr_addr | output | 11 | Transmit frame byte offset |
| buf_wr_word | output | 1 | Write size |
| buf_wr_data | output | 16 | Transmit write data |

## Verification
The bench builds the block with `HOST_AW` = 16 and the window on page 3, so every host address can be visited. With this setting one sweep covers the page decode of R1 over all 65,536 addresses. The default `RAND_WIN` of 118 is kept, so the bench reads every offset of the random window in scrambled and descending orders. It then crosses the window edge with a sequential run and checks the rejection of a jump past it.

// File: rtl/pbuf_win_pkg.sv
package pbuf_win_pkg;
   localparam int WORD_W = 16;
   localparam int PAGE_W = 12;
   localparam int FOFF_W = 11;

   localparam logic [PAGE_W-1:0] OFF_RXSTAT = 12'h400;
   localparam logic [PAGE_W-1:0] OFF_RXLEN  = 12'h402;
   localparam logic [PAGE_W-1:0] OFF_RXFRM  = 12'h404;
   localparam logic [PAGE_W-1:0] OFF_TXFRM  = 12'hA00;

   typedef enum logic [2:0] {
      RGN_NONE,
      RGN_RXSTAT,
      RGN_RXLEN,
      RGN_RXFRM,
      RGN_TXFRM
   } win_region_e;
endpackage

// File: rtl/pbuf_win_decode.sv
module pbuf_win_decode
   import pbuf_win_pkg::*;
#(
   parameter int HOST_AW = 20
) (
   input  logic [HOST_AW-1:0]        addr,
   input  logic [HOST_AW-PAGE_W-1:0] page,
   input  logic                      mem_en,
   output win_region_e               region,
   output logic [FOFF_W-1:0]         off
);
   logic [PAGE_W-1:0] lo;
   assign lo = addr[PAGE_W-1:0];

   always_comb begin
      region = RGN_NONE;
      off    = '0;
      if (mem_en && addr[HOST_AW-1:PAGE_W] == page) begin
         if (lo >= OFF_TXFRM) begin
            region = RGN_TXFRM;
            off    = lo[FOFF_W-1:0] - OFF_TXFRM[FOFF_W-1:0];
         end else if (lo >= OFF_RXFRM) begin
            region = RGN_RXFRM;
            off    = lo[FOFF_W-1:0] - OFF_RXFRM[FOFF_W-1:0];
         end else if (lo >= OFF_RXLEN) begin
            region = RGN_RXLEN;
         end else if (lo >= OFF_RXSTAT) begin
            region = RGN_RXSTAT;
         end
      end
   end
endmodule

// File: rtl/pbuf_align_guard.sv
module pbuf_align_guard
   import pbuf_win_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit,
   input  logic              word,
   input  logic [PAGE_W-1:0] addr_lo,
   output logic              pend
);
   logic              pend_q;
   logic [PAGE_W-1:0] paddr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= 1'b0;
         paddr_q <= '0;
      end else if (commit && !word) begin
         if (!addr_lo[0]) begin
            pend_q  <= 1'b1;
            paddr_q <= addr_lo;
         end else if (addr_lo == paddr_q + PAGE_W'(1)) begin
            pend_q  <= 1'b0;
         end
      end
   end

   assign pend = pend_q;

   // R9
   word_after_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && word) |-> !pend_q);
endmodule

// File: rtl/pbuf_rx_seq.sv
module pbuf_rx_seq
   import pbuf_win_pkg::*;
#(
   parameter int RAND_WIN = 118
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_new,
   input  logic              rd_frm,
   input  logic              commit,
   input  logic              word,
   input  logic [FOFF_W-1:0] off,
   output logic              seq_bad
);
   localparam logic [FOFF_W-1:0] WIN_END = FOFF_W'(RAND_WIN);

   logic [FOFF_W-1:0] ptr_q;

   assign seq_bad = rd_frm && (off >= WIN_END) && (off != ptr_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                ptr_q <= '0;
      else if (frame_new)        ptr_q <= '0;
      else if (commit && rd_frm) ptr_q <= off + (word ? FOFF_W'(2) : FOFF_W'(1));
   end

   // R7
   beyond_win_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && rd_frm && off >= WIN_END) |-> (off == ptr_q));
   // R7
   ptr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_new |=> (ptr_q == '0));
endmodule

// File: rtl/pbuf_host_window.sv
module pbuf_host_window
   import pbuf_win_pkg::*;
#(
   parameter int HOST_AW  = 20,
   parameter int RAND_WIN = 118
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      mem_en,
   input  logic [HOST_AW-PAGE_W-1:0] win_page,
   input  logic [HOST_AW-1:0]        host_addr,
   input  logic                      host_rd,
   input  logic                      host_wr,
   input  logic                      host_word,
   input  logic [WORD_W-1:0]         host_wdata,
   output logic [WORD_W-1:0]         host_rdata,
   output logic                      host_ready,
   output logic                      host_err,
   input  logic [WORD_W-1:0]         rx_status,
   input  logic [WORD_W-1:0]         rx_length,
   input  logic                      rx_frame_new,
   output logic                      buf_rd_en,
   output logic [FOFF_W-1:0]         buf_rd_addr,
   output logic                      buf_rd_word,
   input  logic [WORD_W-1:0]         buf_rd_data,
   output logic                      buf_wr_en,
   output logic [FOFF_W-1:0]         buf_wr_addr,
   output logic                      buf_wr_word,
   output logic [WORD_W-1:0]         buf_wr_data
);
   localparam int RX_SPAN = int'(OFF_TXFRM) - int'(OFF_RXFRM);

   if (HOST_AW <= PAGE_W) begin : g_bad_aw
      $error("HOST_AW must exceed the page width");
   end
   if (RAND_WIN < 2 || RAND_WIN >= RX_SPAN) begin : g_bad_win
      $error("RAND_WIN must lie inside the receive frame area");
   end

   win_region_e       region;
   logic [FOFF_W-1:0] off;
   logic              is_rd, is_wr, acc, pend, seq_bad;
   logic              dir_bad, align_bad, reject, commit;
   logic              err_q;

   pbuf_win_decode #(.HOST_AW(HOST_AW)) u_decode (
      .addr   (host_addr),
      .page   (win_page),
      .mem_en (mem_en),
      .region (region),
      .off    (off)
   );

   assign is_rd = host_rd;
   assign is_wr = host_wr && !host_rd;
   assign acc   = (region != RGN_NONE) && (is_rd || is_wr);

   assign dir_bad   = (is_wr && region != RGN_TXFRM) || (is_rd && region == RGN_TXFRM);
   assign align_bad = host_word && (host_addr[0] || pend);
   assign reject    = acc && (dir_bad || align_bad || seq_bad);
   assign commit    = acc && !reject;

   pbuf_align_guard u_align (
      .clk     (clk),
      .rst_n   (rst_n),
      .commit  (commit),
      .word    (host_word),
      .addr_lo (host_addr[PAGE_W-1:0]),
      .pend    (pend)
   );

   pbuf_rx_seq #(.RAND_WIN(RAND_WIN)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_new (rx_frame_new),
      .rd_frm    (is_rd && region == RGN_RXFRM),
      .commit    (commit),
      .word      (host_word),
      .off       (off),
      .seq_bad   (seq_bad)
   );

   always_comb begin
      host_rdata = '0;
      if (commit && is_rd) begin
         unique case (region)
            RGN_RXSTAT: host_rdata = host_word ? rx_status :
               {8'h00, host_addr[0] ? rx_status[15:8] : rx_status[7:0]};
            RGN_RXLEN:  host_rdata = host_word ? rx_length :
               {8'h00, host_addr[0] ? rx_length[15:8] : rx_length[7:0]};
            RGN_RXFRM:  host_rdata = host_word ? buf_rd_data : {8'h00, buf_rd_data[7:0]};
            default:    host_rdata = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      err_q <= 1'b0;
      else if (reject) err_q <= 1'b1;
   end

   assign host_ready  = acc;
   assign host_err    = err_q;
   assign buf_rd_en   = commit && is_rd && region == RGN_RXFRM;
   assign buf_rd_addr = off;
   assign buf_rd_word = host_word;
   assign buf_wr_en   = commit && is_wr && region == RGN_TXFRM;
   assign buf_wr_addr = off;
   assign buf_wr_word = host_word;
   assign buf_wr_data = host_wdata;

   // R2
   ready_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_ready |-> mem_en);
   // R10
   wr_only_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      buf_wr_en |-> (host_wr && !host_rd && host_addr[PAGE_W-1:0] >= OFF_TXFRM));
   // R8
   word_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((buf_rd_en || buf_wr_en) && host_word) |-> !host_addr[0]);
   // R11
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_err |=> host_err);
   // R11
   strobe_one_hot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({buf_rd_en, buf_wr_en}));
endmodule

// File: tb/pbuf_host_window_tb.sv
module pbuf_host_window_tb;
   localparam int CLK_P = 10;
   localparam int AW    = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mem_en = 1'b0;
   logic [3:0]  win_page = 4'h3;
   logic [15:0] host_addr = '0;
   logic        host_rd = 1'b0, host_wr = 1'b0, host_word = 1'b0;
   logic [15:0] host_wdata = '0;
   logic [15:0] host_rdata;
   logic        host_ready, host_err;
   logic [15:0] rx_status = 16'hBEEF, rx_length = 16'h05DC;
   logic        rx_frame_new = 1'b0;
   logic        buf_rd_en, buf_rd_word, buf_wr_en, buf_wr_word;
   logic [10:0] buf_rd_addr, buf_wr_addr;
   logic [15:0] buf_rd_data, buf_wr_data;

   int n_chk = 0, n_fail = 0;
   logic [15:0] s_rdata, s_wrdata;
   logic        s_ready, s_rden, s_wren, s_wrword;
   logic [10:0] s_rdaddr, s_wraddr;

   always #(CLK_P/2) clk = ~clk;

   // buffer model: word at offset n = {~n[7:0], n[7:0]}
   assign buf_rd_data = {~buf_rd_addr[7:0], buf_rd_addr[7:0]};

   pbuf_host_window #(.HOST_AW(AW), .RAND_WIN(118)) u_dut (
      .clk(clk), .rst_n(rst_n), .mem_en(mem_en), .win_page(win_page),
      .host_addr(host_addr), .host_rd(host_rd), .host_wr(host_wr),
      .host_word(host_word), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .host_ready(host_ready), .host_err(host_err),
      .rx_status(rx_status), .rx_length(rx_length), .rx_frame_new(rx_frame_new),
      .buf_rd_en(buf_rd_en), .buf_rd_addr(buf_rd_addr), .buf_rd_word(buf_rd_word),
      .buf_rd_data(buf_rd_data), .buf_wr_en(buf_wr_en), .buf_wr_addr(buf_wr_addr),
      .buf_wr_word(buf_wr_word), .buf_wr_data(buf_wr_data)
   );

   task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic acc(input logic [15:0] a, input logic rd, input logic wsz, input logic [15:0] wd);
      @(negedge clk);
      host_addr = a; host_rd = rd; host_wr = !rd; host_word = wsz; host_wdata = wd;
      #(CLK_P/4);
      s_ready = host_ready; s_rdata = host_rdata; s_rden = buf_rd_en; s_wren = buf_wr_en;
      s_rdaddr = buf_rd_addr; s_wraddr = buf_wr_addr; s_wrword = buf_wr_word; s_wrdata = buf_wr_data;
      @(posedge clk);
      #1;
      host_rd = 1'b0; host_wr = 1'b0;
   endtask

   task automatic frame_pulse();
      @(negedge clk); rx_frame_new = 1'b1;
      @(negedge clk); rx_frame_new = 1'b0;
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #(CLK_P * 190000);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      finish_run();
   end

   initial begin
      int bad;
      do_reset();
      #1;
      // R12
      chk(host_err == 1'b0, "R12", host_err, 0);
      chk(host_ready == 1'b0, "R12", host_ready, 0);

      // R2: decoding off while mem_en low
      acc(16'h3400, 1, 1, 0);
      chk(!s_ready && !s_rden, "R2", s_ready, 0);
      acc(16'h3A00, 0, 1, 16'h1111);
      chk(!s_ready && !s_wren, "R2", s_wren, 0);
      mem_en = 1'b1;

      // R3: status and length
      acc(16'h3400, 1, 1, 0); chk(s_ready && s_rdata == 16'hBEEF, "R3", s_rdata, 16'hBEEF);
      acc(16'h3400, 1, 0, 0); chk(s_rdata == 16'h00EF, "R3", s_rdata, 16'h00EF);
      acc(16'h3401, 1, 0, 0); chk(s_rdata == 16'h00BE, "R3", s_rdata, 16'h00BE);
      acc(16'h3402, 1, 1, 0); chk(s_rdata == 16'h05DC, "R3", s_rdata, 16'h05DC);
      acc(16'h3403, 1, 0, 0); chk(s_rdata == 16'h0005, "R3", s_rdata, 16'h0005);

      // R4 R6: scrambled even word reads in the random window
      bad = 0;
      for (int k = 0; k < 59; k++) begin
         logic [10:0] o;
         o = 11'(((k * 37) % 59) * 2);
         acc(16'h3404 + 16'(o), 1, 1, 0);
         if (!s_rden || s_rdaddr != o || s_rdata != {~o[7:0], o[7:0]}) bad++;
      end
      chk(bad == 0, "R6", bad, 0);
      // R4: descending byte reads
      bad = 0;
      for (int i = 117; i >= 0; i--) begin
         acc(16'h3404 + 16'(i), 1, 0, 0);
         if (!s_rden || s_rdaddr != 11'(i) || s_rdata != {8'h00, 8'(i)}) bad++;
      end
      chk(bad == 0, "R4", bad, 0);
      acc(16'h3405, 1, 0, 0);
      #1;
      chk(host_err == 1'b0, "R6", host_err, 0);

      // R7: sequential run past the window
      frame_pulse();
      acc(16'h3404 + 16'd116, 1, 1, 0);
      bad = 0;
      for (int o = 118; o <= 300; o += 2) begin
         acc(16'h3404 + 16'(o), 1, 1, 0);
         if (!s_rden || s_rdata != {~8'(o), 8'(o)}) bad++;
      end
      chk(bad == 0, "R7", bad, 0);
      acc(16'h3404 + 16'd302, 1, 0, 0);
      acc(16'h3404 + 16'd303, 1, 0, 0);
      acc(16'h3404 + 16'd304, 1, 1, 0);
      #1;
      chk(s_rden && !host_err, "R7", host_err, 0);
      frame_pulse();
      acc(16'h3404 + 16'd306, 1, 1, 0);
      #1;
      // R7 R11: out-of-sequence read after new frame
      chk(s_ready && !s_rden && s_rdata == 0, "R11", s_rdata, 0);
      chk(host_err == 1'b1, "R7", host_err, 1);
      acc(16'h3404 + 16'd2, 1, 1, 0);
      #1;
      chk(host_err == 1'b1, "R11", host_err, 1);

      // R5: transmit writes
      do_reset();
      acc(16'h3A00, 0, 1, 16'h1234);
      chk(s_wren && s_wraddr == 0 && s_wrword && s_wrdata == 16'h1234, "R5", s_wrdata, 16'h1234);
      acc(16'h3A07, 0, 0, 16'h0056);
      chk(s_wren && s_wraddr == 7 && !s_wrword && s_wrdata == 16'h0056, "R5", s_wraddr, 7);
      bad = 0;
      for (int k = 0; k < 16; k++) begin
         acc(16'h3A10 + 16'(2 * k), 0, 1, 16'(k * 3));
         if (!s_wren || s_wraddr != 11'(16 + 2 * k) || s_wrdata != 16'(k * 3)) bad++;
      end
      chk(bad == 0 && !host_err, "R5", bad, 0);

      // R10: direction violations
      acc(16'h3A00, 1, 1, 0);
      #1;
      chk(s_ready && !s_rden && !s_wren && s_rdata == 0 && host_err, "R10", s_rdata, 0);
      do_reset();
      acc(16'h3400, 0, 1, 16'hFFFF);
      #1;
      chk(s_ready && !s_wren && host_err, "R10", s_wren, 0);
      do_reset();
      acc(16'h3410, 0, 1, 16'hFFFF);
      #1;
      chk(!s_wren && host_err, "R10", host_err, 1);

      // R8: word at odd address
      do_reset();
      acc(16'h3405, 1, 1, 0);
      #1;
      chk(s_ready && !s_rden && s_rdata == 0 && host_err, "R8", s_rdata, 0);

      // R9: pending even byte
      do_reset();
      acc(16'h3406, 1, 0, 0);
      acc(16'h3408, 1, 1, 0);
      #1;
      chk(!s_rden && host_err, "R9", s_rden, 0);
      do_reset();
      acc(16'h3406, 1, 0, 0);
      acc(16'h340B, 1, 0, 0);
      acc(16'h340C, 1, 1, 0);
      #1;
      chk(!s_rden && host_err, "R9", s_rden, 0);
      do_reset();
      acc(16'h3406, 1, 0, 0);
      acc(16'h3407, 1, 0, 0);
      acc(16'h3408, 1, 1, 0);
      chk(s_rden && s_rdata == {~8'd4, 8'd4}, "R9", s_rdata, {~8'd4, 8'd4});
      acc(16'h3409, 1, 0, 0);
      acc(16'h340A, 1, 1, 0);
      #1;
      chk(s_rden && !host_err, "R9", host_err, 0);

      // R1: full address sweep with byte reads
      bad = 0;
      for (int a = 0; a < 65536; a++) begin
         logic exp_rdy;
         exp_rdy = (a[15:12] == 4'h3) && (a[11:0] >= 12'h400);
         acc(16'(a), 1, 0, 0);
         if (s_ready != exp_rdy || (!exp_rdy && (s_rden || s_wren))) bad++;
      end
      chk(bad == 0, "R1", bad, 0);

      finish_run();
   end
endmodule